// File: doc/BRIEF.md
# Serial Controller Register Bank

This block is the byte-wide, CPU-facing register file of a classic asynchronous serial controller. It has eight offsets. The CPU uses them to read received bytes and to write bytes for transmission. It also uses them to program the frame format, the modem control lines and the interrupt enables, and to read back line and modem status. Bit 7 of the line control register is a bank bit. While it is set, offsets 0 and 1 reach the two halves of the 16-bit baud divisor instead of the data and interrupt-enable registers.

The receiver core hands over each byte with a one-cycle valid strobe and its per-byte error flags. The transmitter core receives a load strobe with the byte written by the CPU, and it reports its holding-empty and fully-empty conditions. The block keeps one receive holding byte with sticky error flags and watches four modem inputs for changes. It merges the four interrupt sources into one prioritised identification code and one interrupt line. Shifting, FIFO storage and baud generation sit in neighbouring blocks. This block only supplies them with the divisor, the frame fields and the FIFO control pulses.

Top module: `uart_regbank`

## Requirements
- R1: After reset the interrupt enable, line control, modem control, modem status and scratch registers read 0x00. Line status reads 0x60 while both transmitter-empty inputs are 1, identification reads 0x01, and `irq` is 0.
- R2: While line control bit 7 is 1, a write to offset 0 sets divisor bits 7:0 and a write to offset 1 sets divisor bits 15:8. Reads of offsets 0 and 1 return those bytes. In this mode no transmit load occurs and the interrupt enable register keeps its value.
- R3: Scratch (offset 7) and line control (offset 3) read back all 8 bits written. Interrupt enable (offset 1) keeps bits 3:0 and reads 0 in bits 7:4. Modem control (offset 4) keeps bits 4:0 and reads 0 in bits 7:5. Line control drives `word_len` from bits 1:0, `stop_long` from bit 2, `par_en` from bit 3, `par_even` from bit 4, `par_stick` from bit 5 and `break_ctl` from bit 6.
- R4: A receive strobe stores the byte and sets data ready (line status bit 0). A read of offset 0 with the bank bit clear returns the byte and clears data ready. If a new byte arrives in the same cycle as that read, the read returns the old byte and data ready stays 1 with no overrun.
- R5: A receive strobe while data ready is 1 and no data read is in progress sets overrun (line status bit 1), and the new byte replaces the old one.
- R6: The parity, framing and break flags of a received byte set line status bits 2, 3 and 4. Bit 7 reads 1 while any of those three is set. A read of line status (offset 5) clears bits 1 to 4 and, with them, bit 7. A flag arriving in the same cycle as that read is kept.
- R7: Identification (offset 2) bit 0 is 0 while an enabled cause is pending, and bits 2:1 name the highest one. The causes from highest to lowest are: 11 line error (enable bit 2; any of line status bits 1 to 4), 10 receive data (enable bit 0; data ready), 01 transmit holding empty (enable bit 1), and 00 modem change (enable bit 3; any of modem status bits 3:0). Pending causes that are not enabled are not reported.
- R8: The transmit-holding-empty cause becomes pending when `tx_hold_empty` rises from 0 to 1. It stays pending while masked. It is cleared by a data write (offset 0, bank bit clear), which pulses `tx_load` with `tx_data` equal to the byte written, or by a read of identification that reports code 01.
- R9: Modem status bits 7:4 show carrier detect, ring, data set ready and clear to send. Bits 3, 1 and 0 set on any change of carrier detect, data set ready and clear to send. Bit 2 sets when ring goes from 1 to 0. A read of offset 6 clears bits 3:0. A change in the same cycle as that read is kept.
- R10: Modem control bits 0 to 3 drive `dtr`, `rts`, `out1` and `out2`. When bit 4 is set, all four outputs are 0 and modem status takes clear to send from bit 1, data set ready from bit 0, ring from bit 2 and carrier detect from bit 3 instead of from the inputs.
- R11: `irq` is 1 exactly when identification bit 0 is 0. A write to offset 2 sets `fifo_en` from bit 0 and `fifo_trig` from bits 7:6, and pulses `rx_flush` for bit 1 and `tx_flush` for bit 2. Identification bits 7:6 both read as `fifo_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 3 | Register offset |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe; read side effects apply at the clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current offset |
| irq | output | 1 | Interrupt request, active high |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity error of the strobed byte |
| rx_frm_err | input | 1 | Framing error of the strobed byte |
| rx_brk | input | 1 | Break condition with the strobed byte |
| tx_load | output | 1 | Byte handed to the transmitter this cycle |
| tx_data | output | 8 | Byte for the transmitter |
| tx_hold_empty | input | 1 | Transmitter can accept a byte |
| tx_all_empty | input | 1 | Transmitter fully idle |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Character length code |
| stop_long | output | 1 | Long stop period selected |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| par_stick | output | 1 | Stick parity selected |
| break_ctl | output | 1 | Force line to break |
| fifo_en | output | 1 | FIFO mode enabled |
| fifo_trig | output | 2 | Receive FIFO trigger level code |
| rx_flush | output | 1 | Clear receive FIFO pulse |
| tx_flush | output | 1 | Clear transmit FIFO pulse |
| mdm_cts | input | 1 | Clear to send, active high |
| mdm_dsr | input | 1 | Data set ready, active high |
| mdm_ri | input | 1 | Ring indicator, active high |
| mdm_dcd | input | 1 | Carrier detect, active high |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2 |

## Verification
A CPU read and a hardware event can land in the same cycle. Examples are a byte arriving while offset 0 is read, an error flag arriving while line status is read, and a modem input toggling while modem status is read. The bench provokes each collision by raising the read strobe and the event strobe in the same cycle. It samples the value read in that cycle, which must be the old state, and then reads again. The second read must show that the event survived: data ready is still set with no overrun, the new error bit is kept, or the delta bit is still set. The stacked interrupt sequence also runs each clearing read while lower causes stay pending, to confirm that the code steps down one cause at a time.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned OFS_W   = 3;
    localparam int unsigned IEN_W   = 4;
    localparam int unsigned MCR_W   = 5;
    localparam int unsigned MDM_W   = 4;
    localparam int unsigned DIV_W   = 2 * BYTE_W;

    localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_IDENT = 3'd2;
    localparam logic [OFS_W-1:0] OFS_LCTL  = 3'd3;
    localparam logic [OFS_W-1:0] OFS_MCTL  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
    localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;

    typedef enum logic [1:0] {
        CAUSE_MDM  = 2'b00,
        CAUSE_THR  = 2'b01,
        CAUSE_RXD  = 2'b10,
        CAUSE_LINE = 2'b11
    } cause_e;
endpackage

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    input  logic              data_rd,
    input  logic              status_rd,
    output logic [BYTE_W-1:0] hold_byte,
    output logic              data_ready,
    output logic              overrun,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk_det
);
    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic              dr;
        logic              oe;
        logic              pe;
        logic              fe;
        logic              bi;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_rd) begin
            st_d.dr = 1'b0;
        end
        if (status_rd) begin
            st_d.oe = 1'b0;
            st_d.pe = 1'b0;
            st_d.fe = 1'b0;
            st_d.bi = 1'b0;
        end
        // a fresh byte wins over any clearing read in the same cycle
        if (rx_valid) begin
            st_d.hold = rx_byte;
            st_d.dr   = 1'b1;
            if (st_q.dr && !data_rd) st_d.oe = 1'b1;
            if (rx_par_err)          st_d.pe = 1'b1;
            if (rx_frm_err)          st_d.fe = 1'b1;
            if (rx_brk)              st_d.bi = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_byte  = st_q.hold;
    assign data_ready = st_q.dr;
    assign overrun    = st_q.oe;
    assign par_err    = st_q.pe;
    assign frm_err    = st_q.fe;
    assign brk_det    = st_q.bi;

    p_dr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_valid) |=> !data_ready);

    p_overrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && data_ready && !data_rd) |=> (overrun && hold_byte == $past(rx_byte)));

    p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !rx_valid) |=> !(overrun || par_err || frm_err || brk_det));

    p_err_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_par_err) |=> par_err);
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MDM_W-1:0]  pins,      // {dcd, ri, dsr, cts}
    input  logic              loop_en,
    input  logic [MDM_W-1:0]  ctl_out,   // {out2, out1, rts, dtr}
    input  logic              status_rd,
    output logic [BYTE_W-1:0] msr
);
    typedef struct packed {
        logic [MDM_W-1:0] prev;
        logic [MDM_W-1:0] delta;
    } mdm_st_t;

    mdm_st_t st_d, st_q;
    logic [MDM_W-1:0] eff;
    logic [MDM_W-1:0] evt;

    always_comb begin
        // loopback: dcd<-out2, ri<-out1, dsr<-dtr, cts<-rts
        eff = loop_en ? {ctl_out[3], ctl_out[2], ctl_out[0], ctl_out[1]} : pins;
        evt = {eff[3] ^ st_q.prev[3],
               st_q.prev[2] & ~eff[2],
               eff[1] ^ st_q.prev[1],
               eff[0] ^ st_q.prev[0]};
        st_d       = st_q;
        st_d.prev  = eff;
        st_d.delta = (status_rd ? '0 : st_q.delta) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msr = {eff, st_q.delta};

    p_delta_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((msr[3:0] & $past(msr[3:0])) == $past(msr[3:0])));

    p_ring_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msr[6]) |=> msr[2]);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_regbank_pkg::*;
(
    input  logic [IEN_W-1:0] enable,   // {mdm, line, thr, rxd}
    input  logic             line_pend,
    input  logic             rxd_pend,
    input  logic             thr_pend,
    input  logic             mdm_pend,
    output logic             none_pend,
    output cause_e           cause
);
    logic [IEN_W-1:0] act;

    always_comb begin
        act       = {mdm_pend, line_pend, thr_pend, rxd_pend} & enable;
        none_pend = ~|act;
        if (act[2])      cause = CAUSE_LINE;
        else if (act[0]) cause = CAUSE_RXD;
        else if (act[1]) cause = CAUSE_THR;
        else             cause = CAUSE_MDM;
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_hold_empty,
    input  logic              tx_all_empty,
    output logic [DIV_W-1:0]  divisor,
    output logic [1:0]        word_len,
    output logic              stop_long,
    output logic              par_en,
    output logic              par_even,
    output logic              par_stick,
    output logic              break_ctl,
    output logic              fifo_en,
    output logic [1:0]        fifo_trig,
    output logic              rx_flush,
    output logic              tx_flush,
    input  logic              mdm_cts,
    input  logic              mdm_dsr,
    input  logic              mdm_ri,
    input  logic              mdm_dcd,
    output logic              dtr,
    output logic              rts,
    output logic              out1,
    output logic              out2
);
    typedef struct packed {
        logic [IEN_W-1:0]  ier;
        logic [BYTE_W-1:0] lcr;
        logic [MCR_W-1:0]  mcr;
        logic [BYTE_W-1:0] scr;
        logic [BYTE_W-1:0] dll;
        logic [BYTE_W-1:0] dlm;
        logic              fen;
        logic [1:0]        trig;
        logic              thre_pend;
        logic              thre_prev;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ier: '0, lcr: '0, mcr: '0, scr: '0,
        dll: DIV_RST[BYTE_W-1:0], dlm: DIV_RST[DIV_W-1:BYTE_W],
        fen: 1'b0, trig: 2'b00, thre_pend: 1'b0, thre_prev: 1'b1
    };

    ctl_t ctl_d, ctl_q;

    logic              bank_div;
    logic              thr_wr, data_rd, ident_rd, lstat_rd, mstat_rd;
    logic [BYTE_W-1:0] rx_hold;
    logic              rx_dr, rx_oe, rx_pe, rx_fe, rx_bi;
    logic [BYTE_W-1:0] msr, lsr, iir;
    logic              irq_none;
    cause_e            irq_cause;

    // access decode
    always_comb begin
        bank_div = ctl_q.lcr[BYTE_W-1];
        thr_wr   = cpu_wr && cpu_addr == OFS_DATA && !bank_div;
        data_rd  = cpu_rd && cpu_addr == OFS_DATA && !bank_div;
        ident_rd = cpu_rd && cpu_addr == OFS_IDENT;
        lstat_rd = cpu_rd && cpu_addr == OFS_LSTAT;
        mstat_rd = cpu_rd && cpu_addr == OFS_MSTAT;
    end

    uart_rx_status u_rx_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_data),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err),
        .rx_brk     (rx_brk),
        .data_rd    (data_rd),
        .status_rd  (lstat_rd),
        .hold_byte  (rx_hold),
        .data_ready (rx_dr),
        .overrun    (rx_oe),
        .par_err    (rx_pe),
        .frm_err    (rx_fe),
        .brk_det    (rx_bi)
    );

    uart_modem_status u_modem_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      ({mdm_dcd, mdm_ri, mdm_dsr, mdm_cts}),
        .loop_en   (ctl_q.mcr[4]),
        .ctl_out   (ctl_q.mcr[3:0]),
        .status_rd (mstat_rd),
        .msr       (msr)
    );

    uart_irq_prio u_irq_prio (
        .enable    (ctl_q.ier),
        .line_pend (rx_oe | rx_pe | rx_fe | rx_bi),
        .rxd_pend  (rx_dr),
        .thr_pend  (ctl_q.thre_pend),
        .mdm_pend  (|msr[3:0]),
        .none_pend (irq_none),
        .cause     (irq_cause)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (cpu_wr) begin
            case (cpu_addr)
                OFS_DATA:  if (bank_div) ctl_d.dll = cpu_wdata;
                OFS_IEN:   if (bank_div) ctl_d.dlm = cpu_wdata;
                           else          ctl_d.ier = cpu_wdata[IEN_W-1:0];
                OFS_IDENT: begin
                    ctl_d.fen  = cpu_wdata[0];
                    ctl_d.trig = cpu_wdata[BYTE_W-1:BYTE_W-2];
                end
                OFS_LCTL:  ctl_d.lcr = cpu_wdata;
                OFS_MCTL:  ctl_d.mcr = cpu_wdata[MCR_W-1:0];
                OFS_SCR:   ctl_d.scr = cpu_wdata;
                default:   ;
            endcase
        end
        ctl_d.thre_prev = tx_hold_empty;
        if (thr_wr || (ident_rd && !irq_none && irq_cause == CAUSE_THR)) begin
            ctl_d.thre_pend = 1'b0;
        end
        if (tx_hold_empty && !ctl_q.thre_prev) begin
            ctl_d.thre_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    // status views and read mux
    always_comb begin
        lsr = {rx_pe | rx_fe | rx_bi, tx_all_empty, tx_hold_empty,
               rx_bi, rx_fe, rx_pe, rx_oe, rx_dr};
        iir = {{2{ctl_q.fen}}, 3'b000, irq_cause, irq_none};
        case (cpu_addr)
            OFS_DATA:  cpu_rdata = bank_div ? ctl_q.dll : rx_hold;
            OFS_IEN:   cpu_rdata = bank_div ? ctl_q.dlm
                                            : {{(BYTE_W-IEN_W){1'b0}}, ctl_q.ier};
            OFS_IDENT: cpu_rdata = iir;
            OFS_LCTL:  cpu_rdata = ctl_q.lcr;
            OFS_MCTL:  cpu_rdata = {{(BYTE_W-MCR_W){1'b0}}, ctl_q.mcr};
            OFS_LSTAT: cpu_rdata = lsr;
            OFS_MSTAT: cpu_rdata = msr;
            default:   cpu_rdata = ctl_q.scr;
        endcase
    end

    assign irq       = !irq_none;
    assign tx_load   = thr_wr;
    assign tx_data   = cpu_wdata;
    assign divisor   = {ctl_q.dlm, ctl_q.dll};
    assign word_len  = ctl_q.lcr[1:0];
    assign stop_long = ctl_q.lcr[2];
    assign par_en    = ctl_q.lcr[3];
    assign par_even  = ctl_q.lcr[4];
    assign par_stick = ctl_q.lcr[5];
    assign break_ctl = ctl_q.lcr[6];
    assign fifo_en   = ctl_q.fen;
    assign fifo_trig = ctl_q.trig;
    assign rx_flush  = cpu_wr && cpu_addr == OFS_IDENT && cpu_wdata[1];
    assign tx_flush  = cpu_wr && cpu_addr == OFS_IDENT && cpu_wdata[2];
    assign dtr       = ctl_q.mcr[0] && !ctl_q.mcr[4];
    assign rts       = ctl_q.mcr[1] && !ctl_q.mcr[4];
    assign out1      = ctl_q.mcr[2] && !ctl_q.mcr[4];
    assign out2      = ctl_q.mcr[3] && !ctl_q.mcr[4];

    p_div_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == OFS_DATA && bank_div) |=> divisor[7:0] == $past(cpu_wdata));

    p_div_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == OFS_IEN && bank_div) |=>
            (divisor[15:8] == $past(cpu_wdata) && $stable(ctl_q.ier)));

    p_prio_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ier[2] && (rx_oe || rx_pe || rx_fe || rx_bi)) |-> (irq && iir[2:1] == 2'b11));

    p_thr_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_hold_empty) |=> ctl_q.thre_pend);

    p_loop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.mcr[4] |-> !(dtr || rts || out1 || out2));
endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       irq;
    logic       rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_load;
    logic [7:0] tx_data;
    logic       tx_hold_empty = 1'b1, tx_all_empty = 1'b1;
    logic [15:0] divisor;
    logic [1:0] word_len, fifo_trig;
    logic       stop_long, par_en, par_even, par_stick, break_ctl;
    logic       fifo_en, rx_flush, tx_flush;
    logic       mdm_cts = 1'b0, mdm_dsr = 1'b0, mdm_ri = 1'b0, mdm_dcd = 1'b0;
    logic       dtr, rts, out1, out2;

    int checks = 0;
    int errors = 0;
    int load_cnt = 0, rxf_cnt = 0, txf_cnt = 0;
    logic [7:0] last_tx = '0;
    logic [7:0] v;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_regbank u_uart_regbank (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .tx_load(tx_load), .tx_data(tx_data),
        .tx_hold_empty(tx_hold_empty), .tx_all_empty(tx_all_empty), .divisor(divisor),
        .word_len(word_len), .stop_long(stop_long), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .break_ctl(break_ctl), .fifo_en(fifo_en),
        .fifo_trig(fifo_trig), .rx_flush(rx_flush), .tx_flush(tx_flush),
        .mdm_cts(mdm_cts), .mdm_dsr(mdm_dsr), .mdm_ri(mdm_ri), .mdm_dcd(mdm_dcd),
        .dtr(dtr), .rts(rts), .out1(out1), .out2(out2)
    );

    always @(posedge clk) begin
        if (tx_load) begin
            load_cnt <= load_cnt + 1;
            last_tx  <= tx_data;
        end
        if (rx_flush) rxf_cnt <= rxf_cnt + 1;
        if (tx_flush) txf_cnt <= txf_cnt + 1;
    end

    // {offset, write value, expected read-back}
    localparam logic [18:0] VEC [8] = '{
        {3'd7, 8'hA5, 8'hA5},
        {3'd7, 8'h5A, 8'h5A},
        {3'd1, 8'hFF, 8'h0F},
        {3'd3, 8'h1B, 8'h1B},
        {3'd4, 8'hE3, 8'h03},
        {3'd4, 8'h00, 8'h00},
        {3'd3, 8'h00, 8'h00},
        {3'd1, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b, input logic pe, input logic fe, input logic bi);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_par_err = pe; rx_frm_err = fe; rx_brk = bi;
        @(negedge clk);
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic thr_pulse();
        @(negedge clk);
        tx_hold_empty = 1'b0;
        @(negedge clk);
        tx_hold_empty = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(3'd1, v); chk("R1 ier", v, 8'h00);
        rd(3'd3, v); chk("R1 lcr", v, 8'h00);
        rd(3'd4, v); chk("R1 mcr", v, 8'h00);
        rd(3'd5, v); chk("R1 lsr", v, 8'h60);
        rd(3'd2, v); chk("R1 iir", v, 8'h01);
        rd(3'd6, v); chk("R1 msr", v, 8'h00);
        rd(3'd7, v); chk("R1 scr", v, 8'h00);
        chk("R1 irq", irq, 1'b0);

        // R3 read-back table
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            rd(VEC[i][18:16], v);
            chk("R3 readback", v, VEC[i][7:0]);
        end
        wr(3'd3, 8'h7C);
        #1 chk("R3 fields", {word_len, stop_long, par_en, par_even, par_stick, break_ctl}, 7'b00_11111);
        wr(3'd3, 8'h1B);
        #1 chk("R3 fields2", {word_len, stop_long, par_en, par_even, par_stick, break_ctl}, 7'b11_01100);

        // R2 divisor bank
        wr(3'd1, 8'h05);
        wr(3'd3, 8'h83);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        #1 chk("R2 divisor", divisor, 16'h1234);
        rd(3'd0, v); chk("R2 dll read", v, 8'h34);
        rd(3'd1, v); chk("R2 dlm read", v, 8'h12);
        chk("R2 no load", load_cnt, 0);
        wr(3'd3, 8'h03);
        rd(3'd1, v); chk("R2 ier kept", v, 8'h05);
        wr(3'd1, 8'h00);

        // R4 receive
        rx_push(8'h41, 0, 0, 0);
        rd(3'd5, v); chk("R4 dr set", v, 8'h61);
        rd(3'd0, v); chk("R4 data", v, 8'h41);
        rd(3'd5, v); chk("R4 dr clear", v, 8'h60);

        // R5 overrun
        rx_push(8'h11, 0, 0, 0);
        rx_push(8'h22, 0, 0, 0);
        rd(3'd5, v); chk("R5 overrun", v, 8'h63);
        rd(3'd5, v); chk("R6 oe cleared", v, 8'h61);
        rd(3'd0, v); chk("R5 replaced", v, 8'h22);

        // R6 error flags
        rx_push(8'h33, 1, 0, 0);
        rd(3'd5, v); chk("R6 parity", v, 8'hE5);
        rd(3'd5, v); chk("R6 cleared", v, 8'h61);
        rd(3'd0, v);
        rx_push(8'h34, 0, 1, 1);
        rd(3'd5, v); chk("R6 frame break", v, 8'hF9);
        rd(3'd5, v); rd(3'd0, v);

        // R4 same-cycle byte and data read
        rx_push(8'h44, 0, 0, 0);
        @(negedge clk);
        cpu_addr = 3'd0; cpu_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h55;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; rx_valid = 1'b0;
        chk("R4 collide old", v, 8'h44);
        rd(3'd5, v); chk("R4 collide dr no oe", v, 8'h61);
        rd(3'd0, v); chk("R4 collide new", v, 8'h55);

        // R6 same-cycle status read and error
        rx_push(8'h66, 0, 0, 0);
        @(negedge clk);
        cpu_addr = 3'd5; cpu_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h77; rx_par_err = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0; rx_valid = 1'b0; rx_par_err = 1'b0;
        chk("R6 collide old", v, 8'h61);
        rd(3'd5, v); chk("R6 collide kept", v, 8'hE7);
        rd(3'd5, v); rd(3'd0, v); chk("R5 collide byte", v, 8'h77);

        // R7 priority stack
        wr(3'd1, 8'h0F);
        mdm_cts = 1'b1;
        rx_push(8'h88, 1, 0, 0);
        thr_pulse();
        #1 chk("R11 irq set", irq, 1'b1);
        rd(3'd2, v); chk("R7 line first", v, 8'h06);
        rd(3'd5, v); chk("R7 lsr", v, 8'hE5);
        rd(3'd2, v); chk("R7 rxd second", v, 8'h04);
        rd(3'd0, v);
        rd(3'd2, v); chk("R7 thr third", v, 8'h02);
        rd(3'd2, v); chk("R8 iir read clears", v, 8'h00);
        rd(3'd6, v); chk("R9 msr cts", v, 8'h11);
        rd(3'd2, v); chk("R7 none", v, 8'h01);
        #1 chk("R11 irq clear", irq, 1'b0);

        // R7 mask, R8 pending while masked then cleared by data write
        wr(3'd1, 8'h01);
        thr_pulse();
        rd(3'd2, v); chk("R7 masked", v, 8'h01);
        wr(3'd1, 8'h02);
        #1 chk("R8 kept while masked", irq, 1'b1);
        wr(3'd0, 8'h99);
        #1 chk("R8 load count", load_cnt, 1);
        chk("R8 load data", last_tx, 8'h99);
        chk("R8 write clears", irq, 1'b0);
        rd(3'd2, v); chk("R8 iir after write", v, 8'h01);
        wr(3'd1, 8'h00);

        // R9 modem status
        mdm_ri = 1'b1;
        rd(3'd6, v); chk("R9 ring rise", v, 8'h50);
        mdm_ri = 1'b0;
        rd(3'd6, v); chk("R9 ring trail", v, 8'h14);
        rd(3'd6, v); chk("R9 cleared", v, 8'h10);
        mdm_dcd = 1'b1; mdm_dsr = 1'b1;
        rd(3'd6, v); chk("R9 dcd dsr", v, 8'hBA);
        rd(3'd6, v); chk("R9 cleared2", v, 8'hB0);
        mdm_dcd = 1'b0; mdm_dsr = 1'b0; mdm_cts = 1'b0;
        rd(3'd6, v); chk("R9 falls", v, 8'h0B);
        rd(3'd6, v); chk("R9 idle", v, 8'h00);
        @(negedge clk);
        cpu_addr = 3'd6; cpu_rd = 1'b1; mdm_cts = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
        chk("R9 collide live", v, 8'h10);
        rd(3'd6, v); chk("R9 collide kept", v, 8'h11);
        mdm_cts = 1'b0;
        rd(3'd6, v); rd(3'd6, v); chk("R9 idle2", v, 8'h00);

        // R10 modem control and loopback
        wr(3'd4, 8'h03);
        #1 chk("R10 pins", {out2, out1, rts, dtr}, 4'b0011);
        rd(3'd6, v); chk("R10 no loop msr", v, 8'h00);
        wr(3'd4, 8'h1F);
        #1 chk("R10 loop quiet", {out2, out1, rts, dtr}, 4'b0000);
        rd(3'd6, v); chk("R10 loop msr", v, 8'hFB);
        rd(3'd6, v); chk("R10 loop msr2", v, 8'hF0);
        wr(3'd4, 8'h10);
        rd(3'd6, v); chk("R10 loop drop", v, 8'h0F);
        wr(3'd4, 8'h00);
        rd(3'd6, v); chk("R10 exit", v, 8'h00);

        // R11 fifo control
        wr(3'd2, 8'hC7);
        #1 chk("R11 fifo fields", {fifo_en, fifo_trig}, 3'b111);
        chk("R11 flush pulses", {rxf_cnt[3:0], txf_cnt[3:0]}, 8'h11);
        rd(3'd2, v); chk("R11 iir fifo", v, 8'hC1);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R11 iir plain", v, 8'h01);
        chk("R11 flush once", {rxf_cnt[3:0], txf_cnt[3:0]}, 8'h11);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule